// File: doc/BRIEF.md
# Integer ALU With Status Flags

This block is a registered integer arithmetic and logic unit with a status flag output. It adds, subtracts, adds with carry, subtracts with borrow, and performs bitwise OR, AND and XOR. It also has a compare that subtracts and a test that ANDs. Those two operations only update the flags. Each operation runs at an operand size of 8 bits, 16 bits or the full data width. The flags are taken from the active width. The result bits above the active width come unchanged from the first operand.

The block produces four status flags: carry, zero, overflow and sign. Carry follows borrow semantics for subtraction and compare. The current carry flag enters through its own input, so a chain of add-with-carry or subtract-with-borrow operations can build arithmetic wider than one word. Every output is registered, and each result appears one clock after its operands. A write-enable tells the surrounding datapath whether to store the result.

Top module: `intalu_core`

## Requirements
- R1: With op code 0 (add), the result is A+B within the active width, and carry is the carry out of the top active bit. With op code 2 (add with carry), carry_in is also added at bit 0.
- R2: With op code 1 (subtract), the result is A-B within the active width. With op code 3 (subtract with borrow), carry_in is also subtracted at bit 0. Carry is set exactly when the unsigned subtrahend, plus any borrow, exceeds A.
- R3: For op codes 0, 1, 2, 3 and 7, overflow is set exactly when the signed result does not fit in the active width. This is the case when the carry into the sign bit differs from the carry out of it.
- R4: For every op code from 0 to 8, zero is set when all active result bits are 0, and sign equals the top active result bit.
- R5: Op codes 4 (OR), 5 (AND) and 6 (XOR) give the bitwise result and clear both carry and overflow.
- R6: Op code 7 (compare) sets the flags as a subtract does, and op code 8 (test) sets the flags as an AND does. For both, wr_en_o is 0.
- R7: size_sel 0 selects 8 bits, 1 selects 16 bits, and 2 or 3 selects the full width. At a narrow size, the result bits above the active width equal A's bits, and the flags come from the narrow field only.
- R8: Op codes 9 to 15 are not operations. The flags keep their previous value, wr_en_o is 0, and result_o equals A.
- R9: While rst_n is low at a clock edge, result_o, wr_en_o and all flags become 0 on that edge.
- R10: Outputs change only on a rising clock edge. They reflect the inputs sampled on that edge, so the latency is one cycle.
- R11: wr_en_o is 1 for op codes 0 to 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| opnd_a | input | DATA_W | First operand; also supplies the result bits above the active width |
| opnd_b | input | DATA_W | Second operand |
| op_sel | input | 4 | Operation code (0 add, 1 sub, 2 adc, 3 sbb, 4 or, 5 and, 6 xor, 7 cmp, 8 test) |
| size_sel | input | 2 | Operand size: 0 = 8 bits, 1 = 16 bits, 2 or 3 = full width |
| carry_in | input | 1 | Current carry flag, used by op codes 2 and 3 |
| result_o | output | DATA_W | Registered result |
| wr_en_o | output | 1 | Result is to be stored |
| flag_c_o | output | 1 | Carry / borrow flag |
| flag_z_o | output | 1 | Zero flag |
| flag_o_o | output | 1 | Signed overflow flag |
| flag_s_o | output | 1 | Sign flag |

## Verification
The bench builds the block with the default DATA_W of 32. At that value, the three adder lanes (8, 16 and 32 bits) are all separate, so each lane's carry and overflow can be reached on its own. Operands at the sign and carry boundaries (0x7F, 0xFF, 0x7FFF, 0x7FFFFFFF, 0xFFFFFFFF) are driven at each size. This shows that the flags come from the active field and that A's upper bits pass through unchanged.

// File: rtl/intalu_pkg.sv
// Shared definitions for the integer ALU: operation codes and flag bundle.
// Assumes op codes 9..15 are not operations.
package intalu_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_ADC  = 4'd2,
        OP_SBB  = 4'd3,
        OP_OR   = 4'd4,
        OP_AND  = 4'd5,
        OP_XOR  = 4'd6,
        OP_CMP  = 4'd7,
        OP_TEST = 4'd8
    } alu_op_e;

    typedef struct packed {
        logic c;
        logic z;
        logic o;
        logic s;
    } alu_flags_t;

    localparam int NUM_LANES = 3;

endpackage

// File: rtl/intalu_addsub.sv
// One adder lane of width W. It performs add or subtract, with an optional carry/borrow in.
// Subtraction is A + ~B + ~borrow. The carry flag it returns is already a borrow for subtraction.
// Assumes W >= 2.
module intalu_addsub #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         sub_i,
    input  logic         use_cin_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o,
    output logic         carry_o,
    output logic         ovf_o
);

    logic [W-1:0] b_eff;
    logic         cin_eff;
    logic [W:0]   sum_ext;
    logic         c_into_sign;

    // Form the adder inputs and raw sum, and derive the carry and overflow of this lane
    always_comb begin
        b_eff       = sub_i ? ~b_i : b_i;
        cin_eff     = sub_i ? ~(use_cin_i & cin_i) : (use_cin_i & cin_i);
        sum_ext     = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, cin_eff};
        c_into_sign = a_i[W-1] ^ b_eff[W-1] ^ sum_ext[W-1];
        sum_o       = sum_ext[W-1:0];
        carry_o     = sub_i ? ~sum_ext[W] : sum_ext[W];
        ovf_o       = c_into_sign ^ sum_ext[W];
    end

endmodule

// File: rtl/intalu_logic.sv
// Bitwise unit for OR, AND and XOR. The test operation uses the AND path.
// Assumes the caller ignores the output for non-logic op codes.
module intalu_logic #(
    parameter int W = 32
) (
    input  logic [3:0]   op_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] res_o
);
    import intalu_pkg::*;

    // Select the bitwise function for the given op code
    always_comb begin
        unique case (alu_op_e'(op_i))
            OP_OR:   res_o = a_i | b_i;
            OP_XOR:  res_o = a_i ^ b_i;
            default: res_o = a_i & b_i;
        endcase
    end

endmodule

// File: rtl/intalu_select.sv
// Result and flag selection. It picks the lane for the active size and merges in A's upper bits,
// then computes zero and sign from the active field and decides write-enable.
// Assumes DATA_W >= 16 and the lane order 8, 16, full width.
module intalu_select #(
    parameter int DATA_W = 32
) (
    input  logic [3:0]                                op_i,
    input  logic [1:0]                                lane_i,
    input  logic [DATA_W-1:0]                         a_i,
    input  logic [intalu_pkg::NUM_LANES-1:0][DATA_W-1:0] lane_sum_i,
    input  logic [intalu_pkg::NUM_LANES-1:0]          lane_c_i,
    input  logic [intalu_pkg::NUM_LANES-1:0]          lane_o_i,
    input  logic [DATA_W-1:0]                         logic_res_i,
    output logic [DATA_W-1:0]                         res_o,
    output intalu_pkg::alu_flags_t                    flags_o,
    output logic                                      wr_en_o,
    output logic                                      valid_o
);
    import intalu_pkg::*;

    localparam logic [DATA_W-1:0] MASK8  = DATA_W'(8'hFF);
    localparam logic [DATA_W-1:0] MASK16 = DATA_W'(16'hFFFF);

    logic [DATA_W-1:0] mask;
    logic [DATA_W-1:0] core;
    logic              arith;
    logic              top_bit;

    // Classify the op code as arithmetic, logic or not an operation
    always_comb begin
        arith   = 1'b0;
        valid_o = 1'b1;
        wr_en_o = 1'b0;
        unique case (alu_op_e'(op_i))
            OP_ADD, OP_SUB, OP_ADC, OP_SBB: begin arith = 1'b1; wr_en_o = 1'b1; end
            OP_OR, OP_AND, OP_XOR:          wr_en_o = 1'b1;
            OP_CMP:                         arith = 1'b1;
            OP_TEST:                        ;
            default:                        valid_o = 1'b0;
        endcase
    end

    // Pick the active-width mask and sign position
    always_comb begin
        core = arith ? lane_sum_i[lane_i] : logic_res_i;
        unique case (lane_i)
            2'd0:    begin mask = MASK8;           top_bit = core[7];        end
            2'd1:    begin mask = MASK16;          top_bit = core[15];       end
            default: begin mask = {DATA_W{1'b1}};  top_bit = core[DATA_W-1]; end
        endcase
    end

    // Merge the result and build the flags from the active field
    always_comb begin
        res_o     = valid_o ? ((core & mask) | (a_i & ~mask)) : a_i;
        flags_o.z = ((core & mask) == '0);
        flags_o.s = top_bit;
        flags_o.c = arith ? lane_c_i[lane_i] : 1'b0;
        flags_o.o = arith ? lane_o_i[lane_i] : 1'b0;
    end

endmodule

// File: rtl/intalu_core.sv
// Top of the integer ALU. Three adder lanes (8, 16, full width) are built by a generate loop.
// Results, write-enable and flags are registered, so the latency is one cycle.
// Reset is synchronous and active low. Assumes DATA_W >= 16.
module intalu_core #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic [3:0]        op_sel,
    input  logic [1:0]        size_sel,
    input  logic              carry_in,
    output logic [DATA_W-1:0] result_o,
    output logic              wr_en_o,
    output logic              flag_c_o,
    output logic              flag_z_o,
    output logic              flag_o_o,
    output logic              flag_s_o
);
    import intalu_pkg::*;

    logic [NUM_LANES-1:0][DATA_W-1:0] lane_sum;
    logic [NUM_LANES-1:0]             lane_c;
    logic [NUM_LANES-1:0]             lane_o;
    logic [DATA_W-1:0]                logic_res;
    logic [DATA_W-1:0]                nxt_res;
    alu_flags_t                       nxt_flags;
    alu_flags_t                       flags_q;
    logic                             nxt_wr;
    logic                             nxt_valid;
    logic                             is_sub;
    logic                             use_cin;
    logic [1:0]                       lane_idx;

    // Decode subtract, carry-in use and lane index
    always_comb begin
        is_sub   = (op_sel == OP_SUB) || (op_sel == OP_SBB) || (op_sel == OP_CMP);
        use_cin  = (op_sel == OP_ADC) || (op_sel == OP_SBB);
        lane_idx = (size_sel == 2'd0) ? 2'd0 : (size_sel == 2'd1) ? 2'd1 : 2'd2;
    end

    for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
        localparam int LW = (k == 0) ? 8 : (k == 1) ? 16 : DATA_W;
        logic [LW-1:0] sum_w;
        intalu_addsub #(.W(LW)) addsub_i (
            .a_i       (opnd_a[LW-1:0]),
            .b_i       (opnd_b[LW-1:0]),
            .sub_i     (is_sub),
            .use_cin_i (use_cin),
            .cin_i     (carry_in),
            .sum_o     (sum_w),
            .carry_o   (lane_c[k]),
            .ovf_o     (lane_o[k])
        );
        assign lane_sum[k] = DATA_W'(sum_w);
    end

    intalu_logic #(.W(DATA_W)) logic_i (
        .op_i  (op_sel),
        .a_i   (opnd_a),
        .b_i   (opnd_b),
        .res_o (logic_res)
    );

    intalu_select #(.DATA_W(DATA_W)) select_i (
        .op_i        (op_sel),
        .lane_i      (lane_idx),
        .a_i         (opnd_a),
        .lane_sum_i  (lane_sum),
        .lane_c_i    (lane_c),
        .lane_o_i    (lane_o),
        .logic_res_i (logic_res),
        .res_o       (nxt_res),
        .flags_o     (nxt_flags),
        .wr_en_o     (nxt_wr),
        .valid_o     (nxt_valid)
    );

    // Register the result and write-enable, and update the flags only for real operations
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_o <= '0;
            wr_en_o  <= 1'b0;
            flags_q  <= '0;
        end else begin
            result_o <= nxt_res;
            wr_en_o  <= nxt_wr;
            if (nxt_valid) flags_q <= nxt_flags;
        end
    end

    assign flag_c_o = flags_q.c;
    assign flag_z_o = flags_q.z;
    assign flag_o_o = flags_q.o;
    assign flag_s_o = flags_q.s;

endmodule

// File: rtl/intalu_chk.sv
// Assertion checker for intalu_core. It relates the registered outputs to the inputs of the previous cycle.
// Assumes it is attached by the bind below.
module intalu_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] opnd_a,
    input logic [3:0]        op_sel,
    input logic [1:0]        size_sel,
    input logic [DATA_W-1:0] result_o,
    input logic              wr_en_o,
    input logic              flag_c_o,
    input logic              flag_z_o,
    input logic              flag_o_o,
    input logic              flag_s_o
);

    // R6
    flagonly_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(op_sel) == 4'd7 || $past(op_sel) == 4'd8)) |-> !wr_en_o);

    // R5
    logic_clears_co_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_sel) >= 4'd4 && $past(op_sel) <= 4'd6) |-> (!flag_c_o && !flag_o_o));

    // R8
    undef_holds_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_sel) > 4'd8)
        |-> ($stable(flag_c_o) && $stable(flag_z_o) && $stable(flag_o_o) && $stable(flag_s_o) && !wr_en_o));

    // R7
    narrow_upper_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(size_sel) == 2'd0) |-> (result_o[DATA_W-1:8] == $past(opnd_a[DATA_W-1:8])));

    // R4
    full_zero_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(size_sel) >= 2'd2 && $past(op_sel) <= 4'd6)
        |-> (flag_z_o == (result_o == '0) && flag_s_o == result_o[DATA_W-1]));

    // R11
    write_ops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_sel) <= 4'd6) |-> wr_en_o);

endmodule

bind intalu_core intalu_chk #(.DATA_W(DATA_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .opnd_a   (opnd_a),
    .op_sel   (op_sel),
    .size_sel (size_sel),
    .result_o (result_o),
    .wr_en_o  (wr_en_o),
    .flag_c_o (flag_c_o),
    .flag_z_o (flag_z_o),
    .flag_o_o (flag_o_o),
    .flag_s_o (flag_s_o)
);

// File: tb/intalu_core_tb.sv
// Directed bench for intalu_core. One task per scenario; expected values come from an integer model.
module intalu_core_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic [3:0]  op_sel = '0;
    logic [1:0]  size_sel = '0;
    logic        carry_in = 1'b0;
    logic [31:0] result_o;
    logic        wr_en_o, flag_c_o, flag_z_o, flag_o_o, flag_s_o;

    int checks = 0;
    int bad = 0;
    logic [3:0] held_flags = 4'b0;   // {c,z,o,s} as last set by a real operation

    always #4 clk = ~clk;   // 125 MHz

    intalu_core #(.DATA_W(32)) dut_i (
        .clk(clk), .rst_n(rst_n), .opnd_a(opnd_a), .opnd_b(opnd_b), .op_sel(op_sel),
        .size_sel(size_sel), .carry_in(carry_in), .result_o(result_o), .wr_en_o(wr_en_o),
        .flag_c_o(flag_c_o), .flag_z_o(flag_z_o), .flag_o_o(flag_o_o), .flag_s_o(flag_s_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Independent model: returns result, write-enable, flags {c,z,o,s} and validity
    task automatic model(input logic [3:0] op, input logic [1:0] sz, input logic [31:0] a,
                         input logic [31:0] b, input logic ci, output logic [31:0] res,
                         output logic wr, output logic [3:0] fl, output logic valid);
        int w;
        logic [63:0] mask, am, bm, r, cc;
        logic c, o, sa, sb, sr;
        w = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
        mask = (64'd1 << w) - 64'd1;
        am = {32'd0, a} & mask;
        bm = {32'd0, b} & mask;
        sa = am[w-1];
        sb = bm[w-1];
        c = 1'b0; o = 1'b0;
        valid = (op <= 4'd8);
        wr = (op <= 4'd6);
        cc = (op == 4'd2 || op == 4'd3) ? {63'd0, ci} : 64'd0;
        case (op)
            4'd0, 4'd2: begin
                r = am + bm + cc;
                c = r[w];
                sr = r[w-1];
                o = (sa == sb) && (sr != sa);
            end
            4'd1, 4'd3, 4'd7: begin
                r = am - bm - cc;
                c = (am < bm + cc);
                sr = r[w-1];
                o = (sa != sb) && (sr != sa);
            end
            4'd4: r = am | bm;
            4'd6: r = am ^ bm;
            default: r = am & bm;
        endcase
        sr = r[w-1];
        res = valid ? (32'((r & mask) | ({32'd0, a} & ~mask))) : a;
        fl = {c, ((r & mask) == 64'd0), o, sr};
    endtask

    // Drive one operation, wait one edge, check result/wr/flags
    task automatic run(input string req, input logic [3:0] op, input logic [1:0] sz,
                       input logic [31:0] a, input logic [31:0] b, input logic ci,
                       input bit chk_res);
        logic [31:0] er;
        logic ew, ev;
        logic [3:0] ef;
        model(op, sz, a, b, ci, er, ew, ef, ev);
        if (!ev) ef = held_flags;
        @(negedge clk);
        opnd_a = a; opnd_b = b; op_sel = op; size_sel = sz; carry_in = ci;
        @(negedge clk);
        if (chk_res) check({req, " result"}, result_o, er);
        check({req, " wr_en"}, {31'd0, wr_en_o}, {31'd0, ew});
        check({req, " flags czos"}, {28'd0, flag_c_o, flag_z_o, flag_o_o, flag_s_o}, {28'd0, ef});
        held_flags = ef;
    endtask

    task automatic t_reset();
        // R9: reset clears everything
        check("R9 result", result_o, 32'd0);
        check("R9 wr_en", {31'd0, wr_en_o}, 32'd0);
        check("R9 flags", {28'd0, flag_c_o, flag_z_o, flag_o_o, flag_s_o}, 32'd0);
    endtask

    task automatic t_add();
        run("R1 add", 4'd0, 2'd2, 32'h1234_5678, 32'h1111_1111, 1'b1, 1);
        run("R1 add carry", 4'd0, 2'd2, 32'hFFFF_FFFF, 32'h0000_0001, 1'b0, 1);
        run("R1 adc", 4'd2, 2'd2, 32'hFFFF_FFFE, 32'h0000_0001, 1'b1, 1);
        run("R1 adc no cin", 4'd2, 2'd2, 32'h0000_0010, 32'h0000_0020, 1'b0, 1);
    endtask

    task automatic t_sub();
        run("R2 sub", 4'd1, 2'd2, 32'h0000_0005, 32'h0000_0003, 1'b1, 1);
        run("R2 sub borrow", 4'd1, 2'd2, 32'h0000_0003, 32'h0000_0005, 1'b0, 1);
        run("R2 sbb", 4'd3, 2'd2, 32'h0000_0005, 32'h0000_0005, 1'b1, 1);
        run("R2 sbb equal", 4'd3, 2'd2, 32'h0000_0005, 32'h0000_0004, 1'b1, 1);
    endtask

    task automatic t_overflow();
        run("R3 add ovf", 4'd0, 2'd2, 32'h7FFF_FFFF, 32'h0000_0001, 1'b0, 1);
        run("R3 sub ovf", 4'd1, 2'd2, 32'h8000_0000, 32'h0000_0001, 1'b0, 1);
        run("R3 neg add ovf", 4'd0, 2'd2, 32'h8000_0000, 32'h8000_0000, 1'b0, 1);
        run("R4 zero sign", 4'd1, 2'd2, 32'h0000_0000, 32'h0000_0001, 1'b0, 1);
    endtask

    task automatic t_logic();
        run("R5 or", 4'd4, 2'd2, 32'hF0F0_0000, 32'h0F0F_0001, 1'b1, 1);
        run("R5 and", 4'd5, 2'd2, 32'hF0F0_FFFF, 32'h0F0F_0000, 1'b1, 1);
        run("R5 xor", 4'd6, 2'd2, 32'hAAAA_5555, 32'h5555_5555, 1'b0, 1);
    endtask

    task automatic t_flagonly();
        run("R6 cmp below", 4'd7, 2'd2, 32'h0000_0001, 32'h0000_0002, 1'b0, 0);
        run("R6 cmp signed ovf", 4'd7, 2'd2, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 1'b0, 0);
        run("R6 test", 4'd8, 2'd2, 32'h8000_00F0, 32'h8000_000F, 1'b1, 0);
    endtask

    task automatic t_narrow();
        run("R7 byte add", 4'd0, 2'd0, 32'h1234_56FF, 32'hABCD_EF01, 1'b0, 1);
        run("R7 byte ovf", 4'd0, 2'd0, 32'h0000_007F, 32'h0000_0001, 1'b0, 1);
        run("R7 half sub", 4'd1, 2'd1, 32'h5555_0000, 32'h0000_0001, 1'b0, 1);
        run("R7 half ovf", 4'd0, 2'd1, 32'h0001_7FFF, 32'hFFFF_0001, 1'b0, 1);
        run("R7 size3 full", 4'd0, 2'd3, 32'hFFFF_FFFF, 32'h0000_0001, 1'b0, 1);
    endtask

    task automatic t_undef();
        run("R8 set flags", 4'd1, 2'd2, 32'h0000_0000, 32'h0000_0001, 1'b0, 1);
        run("R8 op9", 4'd9, 2'd2, 32'hDEAD_BEEF, 32'h0000_0000, 1'b1, 1);
        run("R8 op15", 4'd15, 2'd0, 32'h0000_0000, 32'h0000_0000, 1'b0, 1);
    endtask

    task automatic t_latency();
        // R10: inputs changed mid-cycle do not show before the next rising edge
        @(negedge clk);
        opnd_a = 32'h0000_0040; opnd_b = 32'h0000_0002; op_sel = 4'd0; size_sel = 2'd2;
        @(negedge clk);
        opnd_a = 32'h0000_0100;
        #2;
        check("R10 held between edges", result_o, 32'h0000_0042);
        @(negedge clk);
        check("R10 next edge", result_o, 32'h0000_0102);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                t_reset();
                rst_n = 1'b1;
                t_add();
                t_sub();
                t_overflow();
                t_logic();
                t_flagonly();
                t_narrow();
                t_undef();
                t_latency();
                // R9: reset again after activity
                @(negedge clk);
                rst_n = 1'b0;
                @(negedge clk);
                t_reset();
            end
            begin
                repeat (5000) @(posedge clk);
                checks++;
                bad++;
                $display("FAIL watchdog: actual=timeout expected=done");
            end
        join_any
        disable fork;
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule